// File: doc/BRIEF.md
# Real-to-Complex Digital Down-Converter with Automatic Gain Compensation

This block takes a real sample stream from a 14-bit quantizer, one sample per clock when `in_valid` is high, and turns it into a complex baseband stream at one quarter of the accepted input rate. Every sample passes through a numerically controlled oscillator and a mixer. The products then go through two decimate-by-two half-band filters. A final gain stage follows.

The oscillator and mixer cannot be bypassed. A frequency word of zero turns the chain into a plain real decimator: cosine is held at +1 and sine at 0, so the Q rail carries zero. With a zero word the final stage passes data through unchanged, and a full-scale real input still gives a full-scale output. With a non-zero word the final stage doubles the data. This restores full scale, because a real tone splits its energy between a positive and a negative frequency and only one of them survives the filters.

The frequency word is written through a one-cycle write strobe. It takes effect at the next output-frame boundary, and the phase restarts from zero at that point.

Top module: `rc_ddc`

## Requirements
- R1: While reset is asserted, and until the first decimated result, `out_valid` is 0 and `out_i`/`out_q` are 0.
- R2: The oscillator is a 16-bit phase accumulator. The active word is added once per accepted sample, and the sample uses the phase held before the add.
  - Sine is looked up from phase bits 15:14 (quadrant) and 13:10 (index k) in a 16-entry quarter-wave table, L[k] = round(32767·4x(5760−x)/(41472000−x(5760−x))) with x = (2k+1)·90.
  - Odd quadrants read L[15−k], and quadrants 2 and 3 negate the value.
  - Cosine is the sine of phase + 0x4000.
- R3: Each mixer output is round-half-up(x·cos / 2^13) for I and round-half-up(−x·sin / 2^13) for Q, as 16-bit two's complement, where x is the 14-bit two's complement input.
- R4: When the active word is zero, cos = 32767 and sin = 0. Once the filters have flushed, `out_q` is 0.
- R5: Each half-band stage applies taps (−1, 0, 9, 16, 9, 0, −1)/32 to the newest seven samples. It rounds half up, saturates to 16 bits, and emits on every second sample it receives.
- R6: `out_valid` pulses once for every four accepted samples. The result of accepted sample 4n+3 ends output frame n.
- R7: When the active word of the frame's last sample is non-zero, the output is doubled and saturated to [−32768, 32767].
- R8: When that word is zero, the output equals the filter output. A DC input of 8191 yields 32763, and a DC input of −8192 yields −32767.
- R9: A written word becomes active at the next accepted sample whose index is a multiple of four. That sample uses phase 0.
- R10: Cycles with `in_valid` low do not advance the phase, the filters or the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 14 | Real input sample, two's complement |
| cfg_we | input | 1 | Frequency word write strobe |
| cfg_word | input | 16 | Oscillator frequency word |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | In-phase output |
| out_q | output | 16 | Quadrature output |

## Verification
A wrong phase or a wrong table entry changes every later I/Q pair. It shows at the ports within the first output frame after a non-zero word becomes active. A stuck gain flag shows as a factor of two on the first result after the word changes: DC levels come out at 32763 against a saturated 32767. A misaligned frame counter moves the switchover of a new word across a frame, and the result diverges on the next two outputs. Lost filter history shows at once as a mismatch on random streams with gaps.

// File: rtl/rc_ddc_pkg.sv
package rc_ddc_pkg;

  typedef enum logic {
    GAIN_PASS   = 1'b0,
    GAIN_DOUBLE = 1'b1
  } gain_mode_e;

  // Rational sine approximation at the centre of quarter-wave entry k of n.
  function automatic int quarter_sine(input int k, input int n, input int amp);
    longint s, x, prod, num, den;
    s    = 2 * n;
    x    = longint'((2 * k + 1) * 90);
    prod = x * (180 * s - x);
    num  = 4 * prod * longint'(amp);
    den  = 40500 * s * s - prod;
    return int'((num + den / 2) / den);
  endfunction

endpackage

// File: rtl/rc_ddc_nco_mix.sv
module rc_ddc_nco_mix
  import rc_ddc_pkg::*;
#(
  parameter int IN_W    = 14,
  parameter int DW      = 16,
  parameter int PH_W    = 16,
  parameter int LUT_AW  = 4,
  parameter int FRAME_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      in_sample,
  input  logic                 cfg_we,
  input  logic [PH_W-1:0]      cfg_word,
  output logic                 m_valid,
  output logic signed [DW-1:0] m_i,
  output logic signed [DW-1:0] m_q,
  output gain_mode_e           m_mode
);
  localparam int LUT_N  = 1 << LUT_AW;
  localparam int PROD_W = IN_W + DW;
  localparam int SH     = IN_W - 1;
  localparam int AMP    = (1 << (DW - 1)) - 1;
  localparam logic [PH_W-1:0] QTR = {2'b01, {(PH_W-2){1'b0}}};
  localparam logic signed [PROD_W-1:0] RND = PROD_W'(1) <<< (SH - 1);
  localparam logic signed [DW-1:0] ONE = DW'(AMP);

  logic signed [DW-1:0] lut [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    assign lut[k] = DW'(quarter_sine(k, LUT_N, AMP));
  end

  // control state
  logic [PH_W-1:0]    ph_q, ph_d, act_q, act_d, pend_q, pend_d;
  logic               pflag_q, pflag_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic               apply;
  logic [PH_W-1:0]    eff_word, eff_ph, cos_ph;
  logic [LUT_AW-1:0]  s_idx, c_idx;
  logic signed [DW-1:0] s_mag, c_mag, s_val, c_val;

  always_comb begin
    apply    = in_valid && (frm_q == '0) && pflag_q;
    eff_word = apply ? pend_q : act_q;
    eff_ph   = apply ? '0 : ph_q;
    cos_ph   = eff_ph + QTR;
    act_d    = act_q;
    ph_d     = ph_q;
    frm_d    = frm_q;
    pend_d   = pend_q;
    pflag_d  = pflag_q;
    if (in_valid) begin
      act_d = eff_word;
      ph_d  = eff_ph + eff_word;
      frm_d = frm_q + 1'b1;
    end
    if (apply) pflag_d = 1'b0;
    if (cfg_we) begin
      pend_d  = cfg_word;
      pflag_d = 1'b1;
    end
    s_idx = eff_ph[PH_W-3 -: LUT_AW];
    c_idx = cos_ph[PH_W-3 -: LUT_AW];
    s_mag = eff_ph[PH_W-2] ? lut[~s_idx] : lut[s_idx];
    c_mag = cos_ph[PH_W-2] ? lut[~c_idx] : lut[c_idx];
    s_val = eff_ph[PH_W-1] ? -s_mag : s_mag;
    c_val = cos_ph[PH_W-1] ? -c_mag : c_mag;
    if (eff_word == '0) begin
      s_val = '0;
      c_val = ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      act_q   <= '0;
      pend_q  <= '0;
      pflag_q <= 1'b0;
      frm_q   <= '0;
    end else begin
      ph_q    <= ph_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      pflag_q <= pflag_d;
      frm_q   <= frm_d;
    end
  end

  // stage A: operands
  logic                   a_valid;
  logic signed [IN_W-1:0] a_x;
  logic signed [DW-1:0]   a_sin, a_cos;
  gain_mode_e             a_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_x     <= '0;
      a_sin   <= '0;
      a_cos   <= '0;
      a_mode  <= GAIN_PASS;
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        a_x    <= $signed(in_sample);
        a_sin  <= s_val;
        a_cos  <= c_val;
        a_mode <= (eff_word == '0) ? GAIN_PASS : GAIN_DOUBLE;
      end
    end
  end

  // stage B: products with rounding
  logic signed [PROD_W-1:0] p_i, p_q;
  logic signed [DW-1:0]     r_i, r_q;

  always_comb begin
    p_i = PROD_W'(a_x) * PROD_W'(a_cos);
    p_q = -(PROD_W'(a_x) * PROD_W'(a_sin));
    r_i = DW'((p_i + RND) >>> SH);
    r_q = DW'((p_q + RND) >>> SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
      m_mode  <= GAIN_PASS;
    end else begin
      m_valid <= a_valid;
      if (a_valid) begin
        m_i    <= r_i;
        m_q    <= r_q;
        m_mode <= a_mode;
      end
    end
  end

endmodule

// File: rtl/rc_ddc_halfband.sv
module rc_ddc_halfband
  import rc_ddc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  gain_mode_e           in_mode,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output gain_mode_e           out_mode
);
  localparam int ACC_W = DW + 6;
  localparam int HIST  = 6;
  localparam logic signed [ACC_W-1:0] C9   = ACC_W'(9);
  localparam logic signed [ACC_W-1:0] C16  = ACC_W'(16);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(16);
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((1 << (DW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SMIN = -SMAX - ACC_W'(1);

  logic tog_q, tog_d;
  logic emit;
  logic signed [DW-1:0] din  [2];
  logic signed [DW-1:0] dout [2];

  assign din[0] = in_i;
  assign din[1] = in_q;
  assign emit   = in_valid && tog_q;

  always_comb begin
    tog_d = tog_q;
    if (in_valid) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q     <= 1'b0;
      out_valid <= 1'b0;
      out_mode  <= GAIN_PASS;
    end else begin
      tog_q     <= tog_d;
      out_valid <= emit;
      if (emit) out_mode <= in_mode;
    end
  end

  for (genvar r = 0; r < 2; r++) begin : g_rail
    logic signed [DW-1:0]    tap_q [HIST];
    logic signed [DW-1:0]    tap_d [HIST];
    logic signed [ACC_W-1:0] acc, rnd;
    logic signed [DW-1:0]    res, res_q;

    always_comb begin
      acc = C9 * (ACC_W'(tap_q[1]) + ACC_W'(tap_q[3]))
          + C16 * ACC_W'(tap_q[2])
          - ACC_W'(din[r]) - ACC_W'(tap_q[5]);
      rnd = (acc + HALF) >>> 5;
      if (rnd > SMAX)      res = DW'(SMAX);
      else if (rnd < SMIN) res = DW'(SMIN);
      else                 res = DW'(rnd);
      for (int k = 0; k < HIST; k++) tap_d[k] = tap_q[k];
      if (in_valid) begin
        tap_d[0] = din[r];
        for (int k = 1; k < HIST; k++) tap_d[k] = tap_q[k-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < HIST; k++) tap_q[k] <= '0;
        res_q <= '0;
      end else begin
        for (int k = 0; k < HIST; k++) tap_q[k] <= tap_d[k];
        if (emit) res_q <= res;
      end
    end

    assign dout[r] = res_q;
  end

  assign out_i = dout[0];
  assign out_q = dout[1];

endmodule

// File: rtl/rc_ddc_gain.sv
module rc_ddc_gain
  import rc_ddc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  gain_mode_e           in_mode,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam logic signed [DW-1:0] VMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] VMIN = {1'b1, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] dbl_sat(input logic signed [DW-1:0] v);
    if (v[DW-1] != v[DW-2]) return v[DW-1] ? VMIN : VMAX;
    return {v[DW-2:0], 1'b0};
  endfunction

  logic signed [DW-1:0] nxt_i, nxt_q;

  always_comb begin
    nxt_i = in_i;
    nxt_q = in_q;
    if (in_mode == GAIN_DOUBLE) begin
      nxt_i = dbl_sat(in_i);
      nxt_q = dbl_sat(in_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= nxt_i;
        out_q <= nxt_q;
      end
    end
  end

endmodule

// File: rtl/rc_ddc.sv
module rc_ddc
  import rc_ddc_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int DW     = 16,
  parameter int PH_W   = 16,
  parameter int LUT_AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_sample,
  input  logic            cfg_we,
  input  logic [PH_W-1:0] cfg_word,
  output logic            out_valid,
  output logic [DW-1:0]   out_i,
  output logic [DW-1:0]   out_q
);
  localparam int STAGES  = 2;
  localparam int FRAME_W = STAGES;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic                 m_vld;
  logic signed [DW-1:0] m_i, m_q;
  gain_mode_e           m_mode;

  rc_ddc_nco_mix #(
    .IN_W(IN_W), .DW(DW), .PH_W(PH_W), .LUT_AW(LUT_AW), .FRAME_W(FRAME_W)
  ) u_mix (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_word(cfg_word),
    .m_valid(m_vld), .m_i(m_i), .m_q(m_q), .m_mode(m_mode)
  );

  logic                 s_vld  [STAGES+1];
  logic signed [DW-1:0] s_i    [STAGES+1];
  logic signed [DW-1:0] s_q    [STAGES+1];
  gain_mode_e           s_mode [STAGES+1];

  assign s_vld[0]  = m_vld;
  assign s_i[0]    = m_i;
  assign s_q[0]    = m_q;
  assign s_mode[0] = m_mode;

  for (genvar g = 0; g < STAGES; g++) begin : g_hb
    rc_ddc_halfband #(.DW(DW)) u_hb (
      .clk(clk), .rst_n(rst_core_n),
      .in_valid(s_vld[g]), .in_i(s_i[g]), .in_q(s_q[g]), .in_mode(s_mode[g]),
      .out_valid(s_vld[g+1]), .out_i(s_i[g+1]), .out_q(s_q[g+1]),
      .out_mode(s_mode[g+1])
    );
  end

  logic                 g_vld;
  logic                 g_dbl;
  logic signed [DW-1:0] g_i, g_q;
  logic signed [DW-1:0] o_i, o_q;

  assign g_vld = s_vld[STAGES];
  assign g_dbl = (s_mode[STAGES] == GAIN_DOUBLE);
  assign g_i   = s_i[STAGES];
  assign g_q   = s_q[STAGES];

  rc_ddc_gain #(.DW(DW)) u_gain (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid(g_vld), .in_i(g_i), .in_q(g_q), .in_mode(s_mode[STAGES]),
    .out_valid(out_valid), .out_i(o_i), .out_q(o_q)
  );

  assign out_i = o_i;
  assign out_q = o_q;

endmodule

// File: rtl/rc_ddc_chk.sv
module rc_ddc_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [DW-1:0]        out_i,
  input logic                 g_vld,
  input logic                 g_dbl,
  input logic signed [DW-1:0] g_i
);
  localparam logic [DW-1:0] VMAX = {1'b0, {(DW-1){1'b1}}};

  logic [31:0] n_in, n_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (in_valid)  n_in  <= n_in + 32'd1;
      if (out_valid) n_out <= n_out + 32'd1;
    end
  end

  // R1: no output qualifier while held in reset
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (out_valid == 1'b0);
  end

  // R6: never more than one output per four accepted inputs
  assert_rate_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({n_out, 2'b00} <= {2'b00, n_in}));

  // R6: output pulses are never back to back
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: doubled results are even unless clipped high
  assert_double_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (g_vld && g_dbl) |=> (out_valid && (out_i[0] == 1'b0 || out_i == VMAX)));

  // R8: zero-word frames pass the filter output unchanged
  assert_bypass_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (g_vld && !g_dbl) |=> (out_valid && out_i == $past(g_i)));

endmodule

bind rc_ddc rc_ddc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_i(out_i), .g_vld(g_vld), .g_dbl(g_dbl), .g_i(g_i)
);

// File: tb/rc_ddc_tb.sv
module rc_ddc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_sample = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  rc_ddc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_word(cfg_word),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #4 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    n_in    = 0;
  int    n_out   = 0;
  string tag     = "R5";
  int    last_i  = 0;
  int    last_q  = 0;
  int    q_i[$];
  int    q_q[$];
  bit    done    = 0;

  // ---------------- reference model ----------------
  int m_act = 0, m_pend = 0, m_acc = 0, m_frm = 0;
  bit m_pflag = 0;
  int h1i[6], h1q[6], h2i[6], h2q[6];
  bit t1 = 0, t2 = 0;

  function automatic int tbl(int k);
    longint x, p, num, den;
    x = longint'((2 * k + 1) * 90);
    p = x * (5760 - x);
    num = 4 * p * 32767;
    den = 41472000 - p;
    return int'((num + den / 2) / den);
  endfunction

  function automatic int wave(int ph);
    int qd, k, mag;
    qd  = (ph >> 14) & 3;
    k   = (ph >> 10) & 15;
    mag = (qd & 1) ? tbl(15 - k) : tbl(k);
    return (qd & 2) ? -mag : mag;
  endfunction

  function automatic int hb(int n, int h[6]);
    int a;
    a = -n + 9 * h[1] + 16 * h[2] + 9 * h[3] - h[5];
    a = (a + 16) >>> 5;
    if (a > 32767)  a = 32767;
    if (a < -32768) a = -32768;
    return a;
  endfunction

  function automatic int clip16(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_push(int x);
    int ph, c, s, mi, mq, o1i, o1q, o2i, o2q;
    bit dbl;
    if (m_frm == 0 && m_pflag) begin
      m_act = m_pend; ph = 0; m_pflag = 0;
    end else ph = m_acc;
    m_acc = (ph + m_act) & 16'hffff;
    m_frm = (m_frm + 1) % 4;
    dbl = (m_act != 0);
    if (dbl) begin c = wave((ph + 16384) & 16'hffff); s = wave(ph); end
    else begin c = 32767; s = 0; end
    mi = int'((longint'(x) * c + 4096) >>> 13);
    mq = int'((-(longint'(x) * s) + 4096) >>> 13);
    o1i = hb(mi, h1i); o1q = hb(mq, h1q);
    for (int k = 5; k > 0; k--) begin h1i[k] = h1i[k-1]; h1q[k] = h1q[k-1]; end
    h1i[0] = mi; h1q[0] = mq;
    if (t1) begin
      o2i = hb(o1i, h2i); o2q = hb(o1q, h2q);
      for (int k = 5; k > 0; k--) begin h2i[k] = h2i[k-1]; h2q[k] = h2q[k-1]; end
      h2i[0] = o1i; h2q[0] = o1q;
      if (t2) begin
        q_i.push_back(dbl ? clip16(2 * o2i) : o2i);
        q_q.push_back(dbl ? clip16(2 * o2q) : o2q);
      end
      t2 = !t2;
    end
    t1 = !t1;
  endtask

  // ---------------- checks ----------------
  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      n_out++;
      last_i = int'($signed(out_i));
      last_q = int'($signed(out_q));
      if (q_i.size() == 0) check({tag, " unexpected output"}, 1, 0);
      else begin
        check({tag, " I"}, last_i, q_i.pop_front());
        check({tag, " Q"}, last_q, q_q.pop_front());
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(int x);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 14'(x);
    n_in++;
    model_push(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_burst(int x);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 14'(x);
    n_in++;
    model_push(x);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic write_word(int w);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we   = 1'b1;
    cfg_word = 16'(w);
    m_pend   = w & 16'hffff;
    m_pflag  = 1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  int seed = 32'h5eed_0d0c;

  initial begin
    for (int k = 0; k < 6; k++) begin h1i[k]=0; h1q[k]=0; h2i[k]=0; h2q[k]=0; end
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 I in reset", int'(out_i), 0);
    check("R1 Q in reset", int'(out_q), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 I after reset", int'(out_i), 0);

    // zero word: real decimator, full scale in -> full scale out
    tag = "R8";
    for (int k = 0; k < 40; k++) send_burst(8191);
    idle(20);
    check("R8 DC +FS", last_i, 32763);
    check("R4 Q zero", last_q, 0);
    for (int k = 0; k < 40; k++) send_burst(-8192);
    idle(20);
    check("R8 DC -FS", last_i, -32767);

    // non-zero word near DC: doubling saturates
    tag = "R7";
    write_word(1);
    for (int k = 0; k < 40; k++) send_burst(8191);
    idle(20);
    check("R7 doubled clip", last_i, 32767);

    // random stream with gaps under a random word
    tag = "R3";
    write_word(($urandom() & 16'hfffe) | 16'h0100);
    for (int k = 0; k < 400; k++) begin
      if (($urandom() & 3) == 0) begin
        tag = "R10";
        send(int'($urandom() & 16'h3fff) - 8192);
      end else begin
        tag = "R3";
        send_burst(int'($urandom() & 16'h3fff) - 8192);
      end
    end
    idle(20);

    // mid-frame word change
    tag = "R9";
    send_burst(1000); send_burst(-2000);
    write_word(16'h2345);
    for (int k = 0; k < 200; k++) send_burst(int'($urandom() & 16'h3fff) - 8192);
    idle(20);

    // quarter-rate tone at full scale
    tag = "R2";
    write_word(16'h4000);
    for (int k = 0; k < 120; k++) send_burst((k % 2) ? -8192 : 8191);
    idle(20);

    // back to zero word: Q flushes to zero
    tag = "R4";
    write_word(0);
    for (int k = 0; k < 120; k++) send_burst(int'($urandom() & 16'h3fff) - 8192);
    idle(20);
    check("R4 Q flushed", last_q, 0);

    tag = "R5";
    for (int k = 0; k < 64; k++) send_burst((k % 8 < 4) ? 8191 : -8192);
    idle(20);

    check("R6 output count", n_out, n_in / 4);
    check("R6 queue drained", q_i.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule